// File: doc/BRIEF.md
# Serial Link Frame Gearbox

This block sits between a serial transceiver's 40-bit parallel interface and the frame-rate datapath of a link node. On the receive side it collects the incoming 40-bit words, one per fast clock cycle, into a 240-bit history. From that history it cuts a 120-bit window at a bit offset it chooses itself. It moves that offset one bit at a time until the 8-bit header at the top of the window keeps matching the expected value. It then declares lock and presents aligned frames. On the transmit side it takes a 112-bit body, puts the header in front and sends the resulting 120-bit frame as three back-to-back 40-bit words.

All frame-rate work runs on the fast clock, qualified by an enable. An internal divider raises that enable in one cycle out of three. The enable is also an output, so that downstream frame logic can run on the same beat. A run-time code select states how much of the 112-bit received body is payload, and the block returns the body with the check bits cleared.

Top module: `frame_gearbox`

## Requirements
- R1: `ce_o` is high in exactly one cycle of every three consecutive cycles, with no gaps, from the release of reset onward.
- R2: While `rst_ni` is low, `rx_lock_o`, `rx_frame_vld_o`, `ce_o` and `tx_word_o` are all zero.
- R3: Bit order on the wire is MSB first within each 40-bit word. A frame's header is its first 8 bits on the wire and appears on `rx_frame_o[119:112]`. `rx_frame_o[119]` is the earliest received bit.
- R4: Whatever the bit offset of the frames in the stream (any of 120), lock is reached after 4 consecutive enable cycles whose window header equals `HDR_VAL`. Each enable cycle with a wrong header while hunting moves the window by one bit. From reset, lock is reached within 248 enable cycles.
- R5: While locked, runs of 1 to 3 consecutive wrong headers do not clear lock or move the window. Frames keep arriving in stream order.
- R6: While locked, the 4th consecutive wrong header clears lock. The frame carrying that 4th wrong header is still flagged valid, and lock is low from the next cycle on.
- R7: `rx_frame_vld_o` is high exactly in the enable cycles where `rx_lock_o` is high. In those cycles `rx_frame_o` holds one whole frame aligned to its header.
- R8: `rx_payload_o` is the received body (`rx_frame_o[111:0]`) with only its top N bits kept and the rest zero. N is 80 for `code_sel_i`=0, 96 for 1, and 112 for 2 or 3. It follows `code_sel_i` in the same cycle.
- R9: `tx_body_i` is sampled only in enable cycles. `tx_word_o` then carries `{HDR_VAL, body}[119:80]`, `[79:40]` and `[39:0]` in the three cycles that follow. Values of `tx_body_i` in other cycles have no effect.
- R10: After lock is lost, the hunt resumes from the next offset and lock is regained on the true boundary, with frames again correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast (recovered) clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_sel_i | input | 2 | Protection code select, sets payload length |
| rx_word_i | input | 40 | Parallel word from the transceiver, one per cycle |
| rx_frame_o | output | 120 | Frame window at the current offset |
| rx_payload_o | output | 112 | Received body with the non-payload bits cleared |
| rx_frame_vld_o | output | 1 | Aligned frame present this cycle |
| rx_lock_o | output | 1 | Frame boundary locked |
| tx_body_i | input | 112 | Body to transmit, sampled on the enable |
| tx_word_o | output | 40 | Parallel word to the transceiver |
| ce_o | output | 1 | Frame-rate enable, one cycle in three |

## Verification
The received window is combinational from the word history. A frame is therefore checked in the enable cycle where `rx_frame_vld_o` is high, and the payload is checked in the same cycle against the code select driven since the previous cycle. Lock changes one cycle after the enable cycle that decides them. The bench waits for the level with a bounded loop, then checks which frame sequence number was the last one flagged valid, which pins the exact decision cycle. A transmit body is driven in an enable cycle and its three words are checked in the first, second and third following cycles, while the body input carries random noise in between. Every output is sampled on the falling edge.

// File: rtl/gb_pkg.sv
package gb_pkg;

  typedef enum logic [1:0] {
    CODE_STRONG   = 2'd0,
    CODE_MEDIUM   = 2'd1,
    CODE_BARE     = 2'd2,
    CODE_BARE_ALT = 2'd3
  } code_sel_e;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;

endpackage

// File: rtl/gb_ce_gen.sv
module gb_ce_gen #(
  parameter int DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ce_o
);

  generate
    if (DIV <= 1) begin : g_always
      assign ce_o = rst_ni;
    end else begin : g_div
      localparam int CNT_W = $clog2(DIV);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        cnt_q <= '0;
        else if (cnt_q == CNT_W'(DIV - 1))  cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
      end

      assign ce_o = rst_ni && (cnt_q == CNT_W'(DIV - 1));

      a_r1_ce_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_o |=> !ce_o);
    end
  endgenerate

endmodule

// File: rtl/gb_rx_align.sv
module gb_rx_align
  import gb_pkg::*;
#(
  parameter int              FRAME_W  = 120,
  parameter int              WORD_W   = 40,
  parameter int              HDR_W    = 8,
  parameter logic [HDR_W-1:0] HDR_VAL = 8'hB4,
  parameter int              LOCK_N   = 4,
  parameter int              UNLOCK_N = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               lock_o
);

  localparam int HIST_W  = 2 * FRAME_W;
  localparam int IDX_W   = $clog2(HIST_W);
  localparam int OFF_W   = $clog2(FRAME_W);
  localparam int CNT_MAX = (LOCK_N > UNLOCK_N) ? LOCK_N : UNLOCK_N;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [HIST_W-1:0] hist_q;
  logic [OFF_W-1:0]  off_q, off_slip;
  logic [CNT_W-1:0]  run_q;
  lock_st_e          st_q;
  logic              hdr_ok;

  // newest word enters at the bottom; older bits sit higher
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[HIST_W-WORD_W-1:0], word_i};
  end

  assign frame_o  = hist_q[IDX_W'(off_q) +: FRAME_W];
  assign hdr_ok   = (frame_o[FRAME_W-1 -: HDR_W] == HDR_VAL);
  assign off_slip = (off_q == OFF_W'(FRAME_W - 1)) ? '0 : off_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      run_q <= '0;
      off_q <= '0;
    end else if (ce_i) begin
      case (st_q)
        ST_HUNT: begin
          if (hdr_ok) begin
            if (run_q == CNT_W'(LOCK_N - 1)) begin
              st_q  <= ST_LOCK;
              run_q <= '0;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end else begin
            run_q <= '0;
            off_q <= off_slip;
          end
        end
        ST_LOCK: begin
          if (!hdr_ok) begin
            if (run_q == CNT_W'(UNLOCK_N - 1)) begin
              st_q  <= ST_HUNT;
              run_q <= '0;
              off_q <= off_slip;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end else begin
            run_q <= '0;
          end
        end
      endcase
    end
  end

  assign lock_o = (st_q == ST_LOCK);

  a_r4_lock_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(ce_i && hdr_ok));

  a_r4_slip_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(off_q) |-> $past(ce_i && !hdr_ok));

  a_r5_offset_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o)) |-> $stable(off_q));

  a_r6_lock_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(ce_i && !hdr_ok));

endmodule

// File: rtl/gb_tx_slicer.sv
module gb_tx_slicer #(
  parameter int               FRAME_W = 120,
  parameter int               WORD_W  = 40,
  parameter int               HDR_W   = 8,
  parameter logic [HDR_W-1:0] HDR_VAL = 8'hB4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ce_i,
  input  logic [FRAME_W-HDR_W-1:0]   body_i,
  output logic [WORD_W-1:0]          word_o
);

  logic [FRAME_W-1:0] frame_d, sreg_q;

  assign frame_d = {HDR_VAL, body_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sreg_q <= '0;
    else if (ce_i) sreg_q <= frame_d;
    else           sreg_q <= sreg_q << WORD_W;
  end

  assign word_o = sreg_q[FRAME_W-1 -: WORD_W];

  a_r9_first_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> (word_o == $past(frame_d[FRAME_W-1 -: WORD_W])));

endmodule

// File: rtl/frame_gearbox.sv
module frame_gearbox
  import gb_pkg::*;
#(
  parameter int               WORD_W          = 40,
  parameter int               WORDS_PER_FRAME = 3,
  parameter int               HDR_W           = 8,
  parameter logic [HDR_W-1:0] HDR_VAL         = 8'hB4,
  parameter int               LOCK_N          = 4,
  parameter int               UNLOCK_N        = 4,
  parameter int               PAY_STRONG      = 80,
  parameter int               PAY_MEDIUM      = 96
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [1:0]                               code_sel_i,
  input  logic [WORD_W-1:0]                        rx_word_i,
  output logic [WORD_W*WORDS_PER_FRAME-1:0]        rx_frame_o,
  output logic [WORD_W*WORDS_PER_FRAME-HDR_W-1:0]  rx_payload_o,
  output logic                                     rx_frame_vld_o,
  output logic                                     rx_lock_o,
  input  logic [WORD_W*WORDS_PER_FRAME-HDR_W-1:0]  tx_body_i,
  output logic [WORD_W-1:0]                        tx_word_o,
  output logic                                     ce_o
);

  localparam int FRAME_W = WORD_W * WORDS_PER_FRAME;
  localparam int BODY_W  = FRAME_W - HDR_W;
  localparam int LEN_W   = $clog2(BODY_W + 1);

  logic              ce;
  logic [LEN_W-1:0]  pay_len;
  logic [BODY_W-1:0] pay_mask;

  gb_ce_gen #(.DIV(WORDS_PER_FRAME)) u_ce (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_o   (ce)
  );

  gb_rx_align #(
    .FRAME_W  (FRAME_W),
    .WORD_W   (WORD_W),
    .HDR_W    (HDR_W),
    .HDR_VAL  (HDR_VAL),
    .LOCK_N   (LOCK_N),
    .UNLOCK_N (UNLOCK_N)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce),
    .word_i  (rx_word_i),
    .frame_o (rx_frame_o),
    .lock_o  (rx_lock_o)
  );

  gb_tx_slicer #(
    .FRAME_W (FRAME_W),
    .WORD_W  (WORD_W),
    .HDR_W   (HDR_W),
    .HDR_VAL (HDR_VAL)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce),
    .body_i (tx_body_i),
    .word_o (tx_word_o)
  );

  always_comb begin
    case (code_sel_e'(code_sel_i))
      CODE_STRONG: pay_len = LEN_W'(PAY_STRONG);
      CODE_MEDIUM: pay_len = LEN_W'(PAY_MEDIUM);
      default:     pay_len = LEN_W'(BODY_W);
    endcase
  end

  // payload is MSB-aligned in the body; check bits trail it
  assign pay_mask       = ~({BODY_W{1'b1}} >> pay_len);
  assign rx_payload_o   = rx_frame_o[BODY_W-1:0] & pay_mask;
  assign rx_frame_vld_o = ce && rx_lock_o;
  assign ce_o           = ce;

endmodule

// File: tb/frame_gearbox_tb_top.sv
`timescale 1ns/1ps
module frame_gearbox_tb_top;

  localparam logic [7:0] HDR = 8'hB4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   code_sel_i = 2'd0;
  logic [39:0]  rx_word_i = '0;
  logic [111:0] tx_body_i = '0;
  logic [119:0] rx_frame_o;
  logic [111:0] rx_payload_o;
  logic         rx_frame_vld_o, rx_lock_o, ce_o;
  logic [39:0]  tx_word_o;

  always #4 clk_i = ~clk_i;

  frame_gearbox #(.HDR_VAL(HDR)) dut_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .code_sel_i     (code_sel_i),
    .rx_word_i      (rx_word_i),
    .rx_frame_o     (rx_frame_o),
    .rx_payload_o   (rx_payload_o),
    .rx_frame_vld_o (rx_frame_vld_o),
    .rx_lock_o      (rx_lock_o),
    .tx_body_i      (tx_body_i),
    .tx_word_o      (tx_word_o),
    .ce_o           (ce_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mix32(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] x;
    x = (a * 32'h9E3779B1) ^ (b * 32'h7F4A7C15);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x;
  endfunction

  function automatic logic [111:0] body_of(input int s);
    logic [31:0] su;
    su = s;
    return {mix32(su, 1), mix32(su, 2), mix32(su, 3), su[15:0]};
  endfunction

  int j_bits = 0;
  int bad_lo = -100;
  int bad_hi = -100;

  function automatic logic [119:0] frame_of(input int f);
    logic [7:0] h;
    h = (f >= bad_lo && f <= bad_hi) ? ~HDR : HDR;
    return {h, body_of(f)};
  endfunction

  function automatic logic [39:0] word_of(input int w);
    logic [39:0]  r;
    logic [31:0]  t;
    logic [119:0] fr;
    for (int i = 0; i < 40; i++) begin
      int n;
      n = w * 40 + i;
      if (n < j_bits) begin
        t = mix32(n, 77);
        r[39-i] = t[0];
      end else begin
        fr = frame_of((n - j_bits) / 120);
        r[39-i] = fr[119 - ((n - j_bits) % 120)];
      end
    end
    return r;
  endfunction

  function automatic logic [111:0] pay_exp(input logic [111:0] b, input logic [1:0] sel);
    int plen;
    plen = (sel == 2'd0) ? 80 : (sel == 2'd1) ? 96 : 112;
    return b & ~({112{1'b1}} >> plen);
  endfunction

  // receive stream driver and monitor
  int  word_idx = 0;
  int  last_seq = -1;
  bit  have_seq = 0;
  int  nvalid = 0;
  int  hunt_ce = 0;
  bit  seen_drop = 0;
  int  ce_seen = 0;
  logic [2:0] ce_hist = '0;

  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        word_idx = 0; have_seq = 0; hunt_ce = 0; ce_seen = 0; ce_hist = '0;
      end else begin
        ce_hist = {ce_hist[1:0], ce_o};
        ce_seen++;
        if (ce_seen >= 3) chk($countones(ce_hist) == 1, "R1 enable cadence", ce_hist, 3'b001);
        chk(rx_frame_vld_o === (ce_o && rx_lock_o), "R7 valid vs lock", rx_frame_vld_o, ce_o && rx_lock_o);
        if (ce_o && !rx_lock_o) hunt_ce++;
        if (!rx_lock_o) begin have_seq = 0; seen_drop = 1; end
        if (rx_frame_vld_o) begin
          int seq;
          logic [119:0] ef;
          seq = int'(rx_frame_o[15:0]);
          ef  = frame_of(seq);
          if (have_seq) chk(seq == last_seq + 1, "R5 frame order", seq, last_seq + 1);
          chk(rx_frame_o[111:0] == ef[111:0], "R7 body", rx_frame_o[111:0], ef[111:0]);
          chk(rx_frame_o[119:112] == ef[119:112], "R3 header position", rx_frame_o[119:112], ef[119:112]);
          chk(rx_payload_o == pay_exp(ef[111:0], code_sel_i), "R8 payload mask",
              rx_payload_o, pay_exp(ef[111:0], code_sel_i));
          last_seq = seq;
          have_seq = 1;
          nvalid++;
        end
        if (ce_o) code_sel_i = 2'($urandom_range(0, 3));
      end
      rx_word_i = word_of(word_idx);
      if (rst_ni) word_idx++;
    end
  end

  // transmit driver and monitor
  initial begin
    int k;
    logic [119:0] exp_fr;
    k = 3;
    exp_fr = '0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        k = 3;
        tx_body_i = '0;
      end else begin
        if (k < 3) begin
          chk(tx_word_o == exp_fr[119 - 40*k -: 40], "R9 tx word", tx_word_o, exp_fr[119 - 40*k -: 40]);
          k++;
        end
        tx_body_i = {$urandom(), $urandom(), $urandom(), 16'($urandom())};
        if (ce_o) begin
          exp_fr = {HDR, tx_body_i};
          k = 0;
        end
      end
    end
  end

  task automatic do_reset();
    @(posedge clk_i); #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(rx_lock_o == 1'b0, "R2 lock in reset", rx_lock_o, 0);
    chk(rx_frame_vld_o == 1'b0, "R2 valid in reset", rx_frame_vld_o, 0);
    chk(ce_o == 1'b0, "R2 enable in reset", ce_o, 0);
    chk(tx_word_o == '0, "R2 tx word in reset", tx_word_o, 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
  endtask

  task automatic run(input int jb);
    int n0;
    j_bits = jb;
    bad_lo = -100;
    bad_hi = -100;
    do_reset();
    for (int i = 0; i < 1000; i++) begin if (rx_lock_o) break; @(negedge clk_i); end
    chk(rx_lock_o == 1'b1, "R4 lock reached", rx_lock_o, 1);
    chk(hunt_ce >= 4 && hunt_ce <= 248, "R4 enables to lock", hunt_ce, 248);
    n0 = nvalid;
    for (int i = 0; i < 200; i++) begin if (nvalid >= n0 + 6) break; @(negedge clk_i); end
    chk(nvalid >= n0 + 6, "R7 frames after lock", nvalid - n0, 6);
    // three bad headers: lock must hold
    seen_drop = 0;
    bad_lo = last_seq + 3;
    bad_hi = bad_lo + 2;
    for (int i = 0; i < 200; i++) begin if (last_seq >= bad_hi + 3) break; @(negedge clk_i); end
    chk(!seen_drop && last_seq >= bad_hi + 3, "R5 lock held", {seen_drop, 32'(last_seq)}, {1'b0, 32'(bad_hi + 3)});
    // four bad headers: lock must clear after the fourth
    bad_lo = last_seq + 3;
    bad_hi = bad_lo + 3;
    for (int i = 0; i < 200; i++) begin if (!rx_lock_o) break; @(negedge clk_i); end
    chk(rx_lock_o == 1'b0, "R6 lock cleared", rx_lock_o, 0);
    chk(last_seq == bad_hi, "R6 last valid frame", last_seq, bad_hi);
    for (int i = 0; i < 1500; i++) begin if (rx_lock_o) break; @(negedge clk_i); end
    n0 = nvalid;
    for (int i = 0; i < 200; i++) begin if (nvalid >= n0 + 3) break; @(negedge clk_i); end
    chk(rx_lock_o && nvalid >= n0 + 3, "R10 relock", nvalid - n0, 3);
  endtask

  initial begin
    void'($urandom(32'd4242));
    run(0);
    run(37);
    run(119);
    run(120 + int'($urandom_range(0, 239)));
    run(int'($urandom_range(1, 359)));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule